// File: doc/BRIEF.md
# Complex-to-Real Digital Upconverter Channel

This block turns a stream of complex baseband samples, delivered at half the output rate, into one real sample stream for a single digital-to-analog converter. Each accepted I/Q pair is doubled in rate by inserting a zero sample and smoothing the result with a fixed seven-tap half-band low-pass filter. The interpolated complex signal is rotated by a numerically controlled oscillator whose frequency and phase offset are programmable. It is then scaled by a programmable gain and rounded, and only the real part of the product is sent out. A per-channel phase offset lets several such channels be lined up against a common reference.

A tone mode drives a fixed in-phase level and a zero quadrature level into the mixer instead of the filtered data. The output is then a continuous wave at the oscillator frequency, with no baseband source connected. Settings go through a parallel write port into shadow registers, and a single update strobe copies them into the working set. The same strobe restarts the oscillator phase and the pipeline, so the phase after every update is known.

Control runs as a three-state machine. IDLE is the state after reset; nothing advances and the output is zero. DATA is baseband mode: input is accepted on every second cycle. TONE is constant-level mode: input is never accepted. The transitions are IDLE to DATA or TONE on the first update strobe, DATA to TONE on a strobe with the mode bit set, and TONE to DATA on a strobe with the mode bit clear. A strobe that keeps the same mode stays in that state and restarts it.

Top module: `upconv_path`

## Requirements
- R1: After reset the block is in IDLE until the first update strobe: `out_sample` is 0, `out_valid` is 0 and `in_ready` is 0 whatever `in_valid` does.
- R2: Writes with `cfg_we` go to shadow registers only. Address 0 holds the 24-bit frequency word, address 1 the 16-bit phase offset (bits 15:0), address 2 the signed Q1.14 gain (bits 15:0, reset value 16384), and address 3 the mode (bit 0, 1 = tone). A write changes the output only after a later `cfg_update`. A write in the same cycle as the strobe is not part of that update.
- R3: `cfg_update` copies the shadow set into the working set, clears the oscillator accumulator and all pipeline state, and restarts the cycle count k at 0 in the next cycle. `out_valid` is low for k = 0..3 and high from k = 4 on, and in cycle k ≥ 4 `out_sample` is the result for interpolated sample n = k − 4. Before n = 0, every sample counts as zero.
- R4: In DATA, `in_ready` is high exactly in the even cycles k = 0, 2, 4, … and is low in any cycle in which `cfg_update` is high. An input is taken when `in_valid` and `in_ready` are both high.
- R5: Interpolation: the zero-stuffed sequence x[k] holds the accepted sample in an even cycle k and 0 otherwise. The filtered output is y[n] = floor((−x[n] + 9·x[n−2] + 16·x[n−3] + 9·x[n−4] − x[n−6]) / 16), computed separately for I and Q.
- R6: Oscillator: acc[n] = n·F mod 2^24. The phase word is p = (acc[23:8] + offset) mod 2^16, and a = p[15:6]. cos and sin are within 1 LSB of round(32767·cos θ) and round(32767·sin θ), with θ = π(2a+1)/1024.
- R7: Mixer: the real product is m[n] = yI[n]·cos[n] − yQ[n]·sin[n].
- R8: Gain and output: out = floor((m·G + 2^28) / 2^29) with G the signed Q1.14 gain, saturated to the range −32768..32767.
- R9: In TONE, the mixer in-phase input is the parameter `TONE_LEVEL` (16384 by default) and the quadrature input is 0, from n = 0. `in_ready` stays low and input data has no effect on the output.
- R10: In DATA, an even cycle without `in_valid` contributes a zero sample, and the output timing does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Shadow register write enable |
| cfg_addr | input | 2 | Shadow register select |
| cfg_wdata | input | 24 | Shadow register write data |
| cfg_update | input | 1 | Apply the shadow set and restart phase and pipeline |
| in_valid | input | 1 | Baseband sample offered |
| in_i | input | 16 | Baseband in-phase sample, signed |
| in_q | input | 16 | Baseband quadrature sample, signed |
| in_ready | output | 1 | Baseband sample taken this cycle when valid |
| out_valid | output | 1 | Output sample is meaningful |
| out_sample | output | 16 | Real output sample, signed |

## Verification
The bench targets the cycle right after an update strobe. A design that kept old pipeline contents or did not clear the accumulator would show a phase or data error in the first valid samples. Writes with no strobe, or in the same cycle as one, are checked against an unchanged output; a design that applied settings at once would drift off the reference frequency or gain. Full-scale inputs with near-maximum gain push the result past 16 bits, and a design that wrapped instead of clamping would flip sign. Gaps in `in_valid` and tone mode with live input check that missing samples read as zero and that tone mode ignores the data port; an error would show as data leaking into the tone or as a shifted interpolation grid.

// File: rtl/upconv_pkg.sv
package upconv_pkg;

    localparam int SAMP_W    = 16;
    localparam int FREQ_W    = 24;
    localparam int PHOFS_W   = 16;
    localparam int LUT_AW    = 10;
    localparam int QUART     = 2 ** (LUT_AW - 2);
    localparam int Y_W       = SAMP_W + 2;
    localparam int MIX_W     = Y_W + SAMP_W + 1;
    localparam int GAIN_FRAC = 14;
    localparam int GAIN_W    = MIX_W + SAMP_W;
    localparam int OUT_SHIFT = (SAMP_W - 1) + GAIN_FRAC;
    localparam int NTAPS     = 7;
    localparam int FIR_SHIFT = 4;
    localparam int PIPE_LAT  = 4;
    localparam int ADDR_W    = 2;
    localparam int WDATA_W   = FREQ_W;
    localparam int AMP       = 2 ** (SAMP_W - 1) - 1;
    localparam int GAIN_ONE  = 2 ** GAIN_FRAC;

    localparam longint ONE_Q28 = longint'(1) << 28;
    localparam longint PI_Q28  = 843314857;

    localparam int signed FIR_TAP [NTAPS] = '{-1, 0, 9, 16, 9, 0, -1};

    localparam logic [ADDR_W-1:0] CFG_FREQ  = 2'd0;
    localparam logic [ADDR_W-1:0] CFG_PHASE = 2'd1;
    localparam logic [ADDR_W-1:0] CFG_GAIN  = 2'd2;
    localparam logic [ADDR_W-1:0] CFG_MODE  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_TONE = 2'd2
    } path_state_e;

    typedef struct packed {
        logic [FREQ_W-1:0]        freq;
        logic [PHOFS_W-1:0]       phase;
        logic signed [SAMP_W-1:0] gain;
        logic                     tone;
    } path_cfg_t;

    // Quarter-wave sine table from a Taylor series in Q28 fixed point,
    // sampled at the centres of the table cells.
    function automatic logic [QUART*SAMP_W-1:0] build_qtab();
        logic [QUART*SAMP_W-1:0] tab;
        longint x, x2, t, s;
        tab = '0;
        for (int i = 0; i < QUART; i++) begin
            x  = (PI_Q28 * longint'(2 * i + 1)) / longint'(4 * QUART);
            x2 = (x * x) / ONE_Q28;
            t  = x;
            s  = x;
            for (int n = 1; n <= 5; n++) begin
                t = -((t * x2) / ONE_Q28) / longint'((2 * n) * (2 * n + 1));
                s = s + t;
            end
            tab[i*SAMP_W +: SAMP_W] = SAMP_W'((s * longint'(AMP) + ONE_Q28 / 2) / ONE_Q28);
        end
        return tab;
    endfunction

endpackage

// File: rtl/upconv_ctrl.sv
module upconv_ctrl
    import upconv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [WDATA_W-1:0] cfg_wdata,
    input  logic               cfg_update,
    output logic               run,
    output logic               tone_sel,
    output logic               in_ready,
    output logic               out_valid,
    output path_cfg_t          act
);
    localparam int FILL_W = $clog2(PIPE_LAT + 1);

    path_cfg_t         shadow_q;
    path_cfg_t         act_q;
    path_state_e       state_q;
    path_state_e       state_d;
    logic              ph_q;
    logic [FILL_W-1:0] fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '{freq: '0, phase: '0, gain: SAMP_W'(GAIN_ONE), tone: 1'b0};
            act_q    <= '{freq: '0, phase: '0, gain: SAMP_W'(GAIN_ONE), tone: 1'b0};
        end else begin
            if (cfg_update) act_q <= shadow_q;
            if (cfg_we) begin
                unique case (cfg_addr)
                    CFG_FREQ:  shadow_q.freq  <= cfg_wdata[FREQ_W-1:0];
                    CFG_PHASE: shadow_q.phase <= cfg_wdata[PHOFS_W-1:0];
                    CFG_GAIN:  shadow_q.gain  <= cfg_wdata[SAMP_W-1:0];
                    CFG_MODE:  shadow_q.tone  <= cfg_wdata[0];
                    default:   ;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cfg_update) state_d = shadow_q.tone ? ST_TONE : ST_DATA;
            ST_DATA: if (cfg_update && shadow_q.tone) state_d = ST_TONE;
            ST_TONE: if (cfg_update && !shadow_q.tone) state_d = ST_DATA;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run      = 1'b0;
        tone_sel = 1'b0;
        in_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DATA: begin
                run      = 1'b1;
                in_ready = !ph_q && !cfg_update;
            end
            ST_TONE: begin
                run      = 1'b1;
                tone_sel = 1'b1;
            end
            default: ;
        endcase
        out_valid = run && (fill_q == FILL_W'(PIPE_LAT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= 1'b0;
            fill_q <= '0;
        end else if (cfg_update) begin
            ph_q   <= 1'b0;
            fill_q <= '0;
        end else if (run) begin
            ph_q <= ~ph_q;
            if (fill_q != FILL_W'(PIPE_LAT)) fill_q <= fill_q + 1'b1;
        end
    end

    assign act = act_q;

    // R4
    ready_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);

    // R3
    update_blanks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |=> !out_valid);

    // R9
    tone_refuses_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tone_sel |-> !in_ready);

endmodule

// File: rtl/upconv_nco.sv
module upconv_nco
    import upconv_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     restart,
    input  logic [FREQ_W-1:0]        freq,
    input  logic [PHOFS_W-1:0]       phase,
    output logic signed [SAMP_W-1:0] cos_o,
    output logic signed [SAMP_W-1:0] sin_o
);
    localparam logic [QUART*SAMP_W-1:0] QTAB = build_qtab();

    function automatic logic signed [SAMP_W-1:0] wave(input logic [LUT_AW-1:0] a);
        logic [LUT_AW-3:0]        idx;
        logic signed [SAMP_W-1:0] mag;
        idx = a[LUT_AW-2] ? ~a[LUT_AW-3:0] : a[LUT_AW-3:0];
        mag = QTAB[idx*SAMP_W +: SAMP_W];
        return a[LUT_AW-1] ? -mag : mag;
    endfunction

    logic [FREQ_W-1:0]        acc_q;
    logic [LUT_AW-1:0]        addr_s;
    logic [LUT_AW-1:0]        addr_c;
    logic signed [SAMP_W-1:0] cos1_q, sin1_q;

    assign addr_s = LUT_AW'((acc_q[FREQ_W-1 -: PHOFS_W] + phase) >> (PHOFS_W - LUT_AW));
    assign addr_c = addr_s + LUT_AW'(QUART);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cos1_q <= '0;
            sin1_q <= '0;
            cos_o  <= '0;
            sin_o  <= '0;
        end else if (restart) begin
            acc_q  <= '0;
            cos1_q <= '0;
            sin1_q <= '0;
            cos_o  <= '0;
            sin_o  <= '0;
        end else if (run) begin
            acc_q  <= acc_q + freq;
            cos1_q <= wave(addr_c);
            sin1_q <= wave(addr_s);
            cos_o  <= cos1_q;
            sin_o  <= sin1_q;
        end
    end

    // R3
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (acc_q == '0));

    // R6
    acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart) |=> (acc_q == $past(acc_q) + $past(freq)));

endmodule

// File: rtl/upconv_interp.sv
module upconv_interp
    import upconv_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     restart,
    input  logic signed [SAMP_W-1:0] x_in,
    output logic signed [Y_W-1:0]    y_out
);
    logic signed [SAMP_W-1:0] tap_q [NTAPS];
    logic signed [31:0]       sum_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < NTAPS; j++) tap_q[j] <= '0;
        end else if (restart) begin
            for (int j = 0; j < NTAPS; j++) tap_q[j] <= '0;
        end else if (run) begin
            tap_q[0] <= x_in;
            for (int j = 1; j < NTAPS; j++) tap_q[j] <= tap_q[j-1];
        end
    end

    always_comb begin
        sum_c = '0;
        for (int j = 0; j < NTAPS; j++)
            sum_c = sum_c + 32'(FIR_TAP[j]) * 32'(tap_q[j]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       y_out <= '0;
        else if (restart) y_out <= '0;
        else if (run)     y_out <= Y_W'(sum_c >>> FIR_SHIFT);
    end

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(y_out));

endmodule

// File: rtl/upconv_path.sv
module upconv_path
    import upconv_pkg::*;
#(
    parameter logic signed [SAMP_W-1:0] TONE_LEVEL = 16'sd16384
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [WDATA_W-1:0]       cfg_wdata,
    input  logic                     cfg_update,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_i,
    input  logic signed [SAMP_W-1:0] in_q,
    output logic                     in_ready,
    output logic                     out_valid,
    output logic signed [SAMP_W-1:0] out_sample
);
    localparam logic signed [GAIN_W-1:0] HALF   = GAIN_W'(1) << (OUT_SHIFT - 1);
    localparam logic signed [GAIN_W-1:0] SAT_HI = GAIN_W'(AMP);
    localparam logic signed [GAIN_W-1:0] SAT_LO = -SAT_HI - GAIN_W'(1);

    logic      run, tone_sel, accept;
    path_cfg_t act;

    upconv_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_update (cfg_update),
        .run        (run),
        .tone_sel   (tone_sel),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .act        (act)
    );

    logic signed [SAMP_W-1:0] cos_w, sin_w;

    upconv_nco u_nco (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (cfg_update),
        .freq    (act.freq),
        .phase   (act.phase),
        .cos_o   (cos_w),
        .sin_o   (sin_w)
    );

    assign accept = in_valid && in_ready;

    logic signed [SAMP_W-1:0] lane_x [2];
    logic signed [Y_W-1:0]    lane_y [2];

    assign lane_x[0] = accept ? in_i : '0;
    assign lane_x[1] = accept ? in_q : '0;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        upconv_interp u_interp (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .restart (cfg_update),
            .x_in    (lane_x[g]),
            .y_out   (lane_y[g])
        );
    end

    logic signed [Y_W-1:0]    mix_i, mix_q_in;
    logic signed [MIX_W-1:0]  prod_c, mix_q;
    logic signed [GAIN_W-1:0] scaled_c, shifted_c;
    logic signed [SAMP_W-1:0] sat_c;

    always_comb begin
        mix_i     = tone_sel ? Y_W'(TONE_LEVEL) : lane_y[0];
        mix_q_in  = tone_sel ? '0 : lane_y[1];
        prod_c    = (MIX_W'(mix_i) * MIX_W'(cos_w)) - (MIX_W'(mix_q_in) * MIX_W'(sin_w));
        scaled_c  = GAIN_W'(mix_q) * GAIN_W'(act.gain);
        shifted_c = (scaled_c + HALF) >>> OUT_SHIFT;
        if (shifted_c > SAT_HI)      sat_c = SAMP_W'(SAT_HI);
        else if (shifted_c < SAT_LO) sat_c = SAMP_W'(SAT_LO);
        else                         sat_c = SAMP_W'(shifted_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mix_q      <= '0;
            out_sample <= '0;
        end else if (cfg_update) begin
            mix_q      <= '0;
            out_sample <= '0;
        end else if (run) begin
            mix_q      <= prod_c;
            out_sample <= sat_c;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (out_sample == '0) && !out_valid);

    // R3
    blank_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |=> (out_sample == '0));

endmodule

// File: tb/test_upconv_path.sv
`timescale 1ns/1ps
module test_upconv_path;
    localparam int  TOL = 4;
    localparam real PI  = 3.14159265358979323846;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        cfg_update = 1'b0;
    logic        in_valid = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic        in_ready, out_valid;
    logic signed [15:0] out_sample;

    always #2 clk = ~clk;

    upconv_path i_upconv_path (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_update(cfg_update), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .in_ready(in_ready), .out_valid(out_valid),
        .out_sample(out_sample)
    );

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R5";

    // reference state
    int      k_m = -1;
    longint  sh_f = 0, ac_f = 0, sh_p = 0, ac_p = 0, sh_g = 16384, ac_g = 16384;
    bit      sh_t = 0, ac_t = 0;
    longint  xi [0:2047];
    longint  xq [0:2047];
    logic [31:0] lf = 32'h1234_5678;

    function automatic longint y_of(bit lane, int n);
        longint s = 0;
        int tp [7] = '{-1, 0, 9, 16, 9, 0, -1};
        for (int j = 0; j < 7; j++)
            if (n - j >= 0) s += tp[j] * (lane ? xq[n-j] : xi[n-j]);
        return s >>> 4;
    endfunction

    function automatic longint ref_out(int n);
        longint acc, p, a, c, s, yi, yq, v, r;
        real th;
        if (n < 0) return 0;
        acc = (longint'(n) * ac_f) & 64'hFF_FFFF;
        p   = ((acc >> 8) + ac_p) & 64'hFFFF;
        a   = p >> 6;
        th  = PI * real'(2 * a + 1) / 1024.0;
        c   = longint'(32767.0 * $cos(th));
        s   = longint'(32767.0 * $sin(th));
        yi  = ac_t ? 16384 : y_of(0, n);
        yq  = ac_t ? 0 : y_of(1, n);
        v   = (yi * c - yq * s) * ac_g;
        r   = (v + (longint'(1) << 28)) >>> 29;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic check(string req, string what, longint act, longint exp, int tol);
        longint d = act - exp;
        n_cmp++;
        if (d > tol || d < -tol) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (k=%0d)", req, what, act, exp, k_m);
        end
    endtask

    task automatic step(bit v, int di, int dq, bit we, int addr, int data, bit upd);
        bit er, ev;
        longint eo;
        @(negedge clk);
        in_valid = v; in_i = 16'(di); in_q = 16'(dq);
        cfg_we = we; cfg_addr = 2'(addr); cfg_wdata = 24'(data); cfg_update = upd;
        #1;
        er = (k_m >= 0) && !ac_t && (k_m % 2 == 0) && !upd;
        ev = (k_m >= 4);
        eo = ev ? ref_out(k_m - 4) : 0;
        check(k_m < 0 ? "R1" : (ac_t ? "R9" : "R4"), "in_ready", longint'(in_ready), longint'(er), 0);
        check(k_m < 0 ? "R1" : "R3", "out_valid", longint'(out_valid), longint'(ev), 0);
        check(k_m < 0 ? "R1" : cur_req, "out_sample", longint'(out_sample), eo, ev ? TOL : 0);
        if (k_m >= 0 && k_m < 2048) begin
            xi[k_m] = (v && er) ? longint'(di) : 0;
            xq[k_m] = (v && er) ? longint'(dq) : 0;
        end
        @(posedge clk);
        if (upd) begin
            ac_f = sh_f; ac_p = sh_p; ac_g = sh_g; ac_t = sh_t; k_m = 0;
            for (int i = 0; i < 2048; i++) begin xi[i] = 0; xq[i] = 0; end
        end else if (k_m >= 0) k_m++;
        if (we) begin
            case (addr)
                0: sh_f = data & 24'hFFFFFF;
                1: sh_p = data & 16'hFFFF;
                2: sh_g = longint'($signed(16'(data)));
                default: sh_t = data[0];
            endcase
        end
    endtask

    task automatic wr(int addr, int data);
        step(0, 0, 0, 1, addr, data, 0);
    endtask

    task automatic upd();
        step(0, 0, 0, 0, 0, 0, 1);
    endtask

    function automatic int rnd(int amp);
        lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
        return int'(lf % (2 * amp + 1)) - amp;
    endfunction

    task automatic feed(int cycles, int amp, int gap);
        for (int c = 0; c < cycles; c++) begin
            int a = rnd(amp);
            int b = rnd(amp);
            step((gap == 0) || (c % gap != 0), a, b, 0, 0, 0, 0);
        end
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset and idle, with input offered
        repeat (3) step(1, 100, 100, 0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        feed(6, 1000, 0);
        // R2: shadow writes alone do not start the path
        wr(0, 24'h100000); wr(1, 0); wr(2, 16384);
        feed(6, 1000, 0);
        // R5 R6 R7: data mode, steady input
        cur_req = "R5";
        upd();
        feed(120, 20000, 0);
        // R2: write without update leaves the output on the old settings
        cur_req = "R2";
        wr(0, 24'h2A0000);
        feed(40, 20000, 0);
        // R2: write in the same cycle as update is left out of that update
        step(0, 0, 0, 1, 2, 8000, 1);
        feed(30, 20000, 0);
        // R8: phase offset, near-maximum gain, full-scale input
        cur_req = "R8";
        wr(1, 16'h4000); wr(2, 32767);
        upd();
        feed(80, 30000, 0);
        // R10: gaps in input, negative gain, odd frequency
        cur_req = "R10";
        wr(0, 24'h0ABCDE); wr(1, 16'h1234); wr(2, 16'hC000);
        upd();
        feed(80, 25000, 3);
        // R9: tone mode ignores live input
        cur_req = "R9";
        wr(3, 1); wr(2, 16384); wr(0, 24'h080000); wr(1, 0);
        upd();
        feed(100, 30000, 0);
        // R3: back to data mode mid-run, phase restarts
        cur_req = "R3";
        wr(3, 0); wr(0, 24'h040000);
        feed(3, 30000, 0);
        upd();
        feed(40, 15000, 0);
        // R7: quadrature only, sin path sign
        cur_req = "R7";
        wr(0, 24'h155555);
        upd();
        for (int c = 0; c < 40; c++) step(1, 0, 12000, 0, 0, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule